// File: doc/BRIEF.md
# Operand-Waiting Reservation Station

This block sits in front of one execution unit and holds micro-operations until their source operands are known. Each clock it can take in one dispatched micro-operation. For each source operand, the micro-operation brings either the operand value, taken from the register file or reorder buffer, or the reorder-buffer tag of the result that will produce it. The station watches several result buses, one of which carries load data. Any waiting operand whose tag appears on one of them takes the broadcast value.

A stored entry is sent to the execution unit once all its operands are present and the unit reports that it has finished its previous operation. If several entries qualify, the oldest goes first. A micro-operation that arrives with every operand ready, while the unit is free and no stored entry is waiting to issue, goes straight to the unit in the same clock and takes no slot. A full flag stalls dispatch. A flush input empties the station in one clock.

Top module: `opwait_rs`

## Requirements
- R1: After reset the station is empty: `iss_valid` and `full` are 0, and nothing issues until something is dispatched.
- R2: At most one micro-operation is taken in per clock, and only when `disp_valid` is 1 and `full` is 0. A dispatch made while `full` is 1 is dropped and never issues.
- R3: A stored entry issues only when all its operands are present and `eu_busy` is 0. `iss_valid` is never 1 while `eu_busy` is 1.
- R4: A pending operand takes the value of a result bus in the clock where `res_vld[b]` is 1 and `res_tag` slice `b` (bits `b*TAGW +: TAGW`) equals its tag. This includes the dispatch clock. The entry can issue in the next clock. Bus 1 carries load data and wakes operands exactly as bus 0 does.
- R5: When `disp_valid` is 1 with all bits of `disp_rdy` set, `eu_busy` is 0, no stored entry is ready and the station is not full, the micro-operation issues in that same clock with its own opcode, destination and values, and it is not stored.
- R6: When more than one stored entry is ready, the one dispatched earliest issues first.
- R7: `full` is 1 exactly when every entry is occupied and no stored entry issues in that clock. While `full` is 1, `iss_valid` is 0. An issue from a full station frees a slot for a dispatch in that same clock.
- R8: While `flush` is 1, `iss_valid` is 0 and any dispatch is dropped. From the next clock on, no previously stored entry remains, even if its tags are later broadcast.
- R9: A ready stored entry takes priority over a same-clock bypass. The dispatched micro-operation is then stored and issues in a later clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | UOPW | Micro-operation opcode/payload |
| disp_dst | input | TAGW | Destination reorder-buffer tag |
| disp_rdy | input | NSRC | Per-operand value-present flags (bit s = operand s) |
| disp_tag | input | NSRC*TAGW | Per-operand source tags (slice s) |
| disp_val | input | NSRC*DATAW | Per-operand values (slice s) |
| res_vld | input | NBUS | Result-bus valid flags (bus 1 = load data) |
| res_tag | input | NBUS*TAGW | Result-bus tags |
| res_val | input | NBUS*DATAW | Result-bus values |
| eu_busy | input | 1 | Execution unit has not finished its prior operation |
| full | output | 1 | Station cannot take a dispatch this clock |
| iss_valid | output | 1 | Issue to execution unit |
| iss_op | output | UOPW | Issued opcode/payload |
| iss_dst | output | TAGW | Issued destination tag |
| iss_val | output | NSRC*DATAW | Issued operand values |

## Verification
Every combination of the two operand-ready flags is dispatched with the unit both idle and busy. Only the all-ready, idle case may bypass. Each stored case is then flushed to show that nothing is left behind. Wakeups are driven on a non-matching tag, on the load bus, and on the same clock as dispatch, which separates a wrong tag compare, an ignored bus and a missed dispatch-time capture. A sequence where the younger entry wakes first shows whether issue order follows age or wakeup order. The same sequence also fills the station and refills it while it drains, which exposes a full flag or slot release that is off by one clock.

// File: rtl/opwait_pkg.sv
package opwait_pkg;
  localparam int RS_DEPTH = 2;
  localparam int ROB_TAGW = 4;
  localparam int OPND_W   = 32;
  localparam int NUM_SRC  = 2;
  localparam int NUM_BUS  = 2;
  localparam int UOP_W    = 8;
endpackage

// File: rtl/opwait_src.sv
module opwait_src #(
  parameter int TAGW  = 4,
  parameter int DATAW = 32,
  parameter int NBUS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  ld_rdy,
  input  logic [TAGW-1:0]       ld_tag,
  input  logic [DATAW-1:0]      ld_val,
  input  logic [NBUS-1:0]       bus_vld,
  input  logic [NBUS*TAGW-1:0]  bus_tag,
  input  logic [NBUS*DATAW-1:0] bus_val,
  output logic                  have,
  output logic [DATAW-1:0]      val
);
  logic             have_q, have_d;
  logic [TAGW-1:0]  tag_q, tag_d;
  logic [DATAW-1:0] val_q, val_d;
  logic [TAGW-1:0]  watch_tag;
  logic             hit, upd;
  logic [DATAW-1:0] hit_val;

  // lowest-numbered matching bus wins; tags are unique in flight
  always_comb begin
    watch_tag = load ? ld_tag : tag_q;
    hit       = 1'b0;
    hit_val   = '0;
    for (int b = 0; b < NBUS; b++) begin
      if (!hit && bus_vld[b] && (bus_tag[b*TAGW +: TAGW] == watch_tag)) begin
        hit     = 1'b1;
        hit_val = bus_val[b*DATAW +: DATAW];
      end
    end
  end

  always_comb begin
    have_d = have_q;
    tag_d  = tag_q;
    val_d  = val_q;
    upd    = load | (~have_q & hit);
    if (load) begin
      tag_d = ld_tag;
      if (ld_rdy) begin
        have_d = 1'b1;
        val_d  = ld_val;
      end else begin
        have_d = hit;
        val_d  = hit_val;
      end
    end else if (!have_q && hit) begin
      have_d = 1'b1;
      val_d  = hit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      tag_q  <= '0;
      val_q  <= '0;
    end else if (upd) begin
      have_q <= have_d;
      tag_q  <= tag_d;
      val_q  <= val_d;
    end
  end

  assign have = have_q;
  assign val  = val_q;
endmodule

// File: rtl/opwait_pick.sv
module opwait_pick #(
  parameter int DEPTH = 2,
  parameter int AW    = 1
) (
  input  logic [DEPTH-1:0]    rdy,
  input  logic [DEPTH*AW-1:0] age,
  output logic [DEPTH-1:0]    grant,
  output logic                any
);
  // a ready entry wins unless a ready entry with a smaller age exists
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      grant[i] = rdy[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && rdy[j] && (age[j*AW +: AW] < age[i*AW +: AW]))
          grant[i] = 1'b0;
      end
    end
    any = |rdy;
  end
endmodule

// File: rtl/opwait_rs.sv
module opwait_rs
  import opwait_pkg::*;
#(
  parameter int DEPTH = RS_DEPTH,
  parameter int TAGW  = ROB_TAGW,
  parameter int DATAW = OPND_W,
  parameter int NSRC  = NUM_SRC,
  parameter int NBUS  = NUM_BUS,
  parameter int UOPW  = UOP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  disp_valid,
  input  logic [UOPW-1:0]       disp_op,
  input  logic [TAGW-1:0]       disp_dst,
  input  logic [NSRC-1:0]       disp_rdy,
  input  logic [NSRC*TAGW-1:0]  disp_tag,
  input  logic [NSRC*DATAW-1:0] disp_val,
  input  logic [NBUS-1:0]       res_vld,
  input  logic [NBUS*TAGW-1:0]  res_tag,
  input  logic [NBUS*DATAW-1:0] res_val,
  input  logic                  eu_busy,
  output logic                  full,
  output logic                  iss_valid,
  output logic [UOPW-1:0]       iss_op,
  output logic [TAGW-1:0]       iss_dst,
  output logic [NSRC*DATAW-1:0] iss_val
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]      v_q, v_d;
  logic [AW-1:0]         age_q [DEPTH];
  logic [AW-1:0]         age_d [DEPTH];
  logic [UOPW-1:0]       op_q  [DEPTH];
  logic [TAGW-1:0]       dst_q [DEPTH];
  logic [NSRC-1:0]       ent_have [DEPTH];
  logic [NSRC*DATAW-1:0] ent_val  [DEPTH];
  logic [DEPTH-1:0]      ent_rdy, grant, alloc_oh, free_v;
  logic [DEPTH*AW-1:0]   age_flat;
  logic                  any_rdy, unit_free, st_issue, accept, bypass, alloc_req;
  logic [AW-1:0]         iss_age, n_keep;

  // per-entry operand slots
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      opwait_src #(.TAGW(TAGW), .DATAW(DATAW), .NBUS(NBUS)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (alloc_oh[i]),
        .ld_rdy (disp_rdy[s]),
        .ld_tag (disp_tag[s*TAGW +: TAGW]),
        .ld_val (disp_val[s*DATAW +: DATAW]),
        .bus_vld(res_vld),
        .bus_tag(res_tag),
        .bus_val(res_val),
        .have   (ent_have[i][s]),
        .val    (ent_val[i][s*DATAW +: DATAW])
      );
    end
    assign ent_rdy[i] = v_q[i] & (&ent_have[i]);
    assign age_flat[i*AW +: AW] = age_q[i];
  end

  opwait_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
    .rdy  (ent_rdy),
    .age  (age_flat),
    .grant(grant),
    .any  (any_rdy)
  );

  // issue / dispatch decisions
  always_comb begin
    unit_free = ~eu_busy & ~flush;
    st_issue  = unit_free & any_rdy;
    full      = (&v_q) & ~st_issue;
    accept    = disp_valid & ~full & ~flush;
    bypass    = accept & (&disp_rdy) & unit_free & ~any_rdy;
    alloc_req = accept & ~bypass;
    free_v    = ~v_q | (grant & {DEPTH{st_issue}});
    alloc_oh  = (free_v & (~free_v + 1'b1)) & {DEPTH{alloc_req}};
  end

  // age bookkeeping: 0 is oldest among valid entries
  always_comb begin
    int cnt;
    cnt     = 0;
    iss_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) iss_age = iss_age | age_q[i];
      if (v_q[i] && !(st_issue && grant[i])) cnt++;
    end
    n_keep = AW'(cnt);
  end

  always_comb begin
    v_d = v_q;
    for (int i = 0; i < DEPTH; i++) begin
      age_d[i] = age_q[i];
      if (st_issue && grant[i])
        v_d[i] = 1'b0;
      else if (st_issue && v_q[i] && (age_q[i] > iss_age))
        age_d[i] = age_q[i] - 1'b1;
      if (alloc_oh[i]) begin
        v_d[i]   = 1'b1;
        age_d[i] = n_keep;
      end
    end
    if (flush) v_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[i] <= '0;
        op_q[i]  <= '0;
        dst_q[i] <= '0;
      end else begin
        age_q[i] <= age_d[i];
        if (alloc_oh[i]) begin
          op_q[i]  <= disp_op;
          dst_q[i] <= disp_dst;
        end
      end
    end
  end

  // issue mux: stored entry or same-clock bypass
  always_comb begin
    iss_valid = st_issue | bypass;
    iss_op    = disp_op;
    iss_dst   = disp_dst;
    iss_val   = disp_val;
    if (st_issue) begin
      iss_op  = '0;
      iss_dst = '0;
      iss_val = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (grant[i]) begin
          iss_op  = iss_op  | op_q[i];
          iss_dst = iss_dst | dst_q[i];
          iss_val = iss_val | ent_val[i];
        end
      end
    end
  end
endmodule

// File: rtl/opwait_rs_chk.sv
module opwait_rs_chk #(
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             eu_busy,
  input logic             full,
  input logic             iss_valid,
  input logic [DEPTH-1:0] grant,
  input logic [DEPTH-1:0] alloc_oh
);
  // R3
  iss_needs_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !eu_busy);
  // R8
  flush_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !iss_valid);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !full);
  // R7
  full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !iss_valid);
  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R2
  one_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_oh));
endmodule

bind opwait_rs opwait_rs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .eu_busy  (eu_busy),
  .full     (full),
  .iss_valid(iss_valid),
  .grant    (grant),
  .alloc_oh (alloc_oh)
);

// File: tb/opwait_rs_bench.sv
module opwait_rs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, flush, disp_valid, eu_busy;
  logic [7:0]  disp_op;
  logic [3:0]  disp_dst;
  logic [1:0]  disp_rdy;
  logic [7:0]  disp_tag;
  logic [63:0] disp_val;
  logic [1:0]  res_vld;
  logic [7:0]  res_tag;
  logic [63:0] res_val;
  logic        full, iss_valid;
  logic [7:0]  iss_op;
  logic [3:0]  iss_dst;
  logic [63:0] iss_val;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opwait_rs u_opwait_rs (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
    .disp_op(disp_op), .disp_dst(disp_dst), .disp_rdy(disp_rdy),
    .disp_tag(disp_tag), .disp_val(disp_val), .res_vld(res_vld),
    .res_tag(res_tag), .res_val(res_val), .eu_busy(eu_busy), .full(full),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst), .iss_val(iss_val)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_iss(input string req, input bit ev, input logic [7:0] eop,
                         input logic [63:0] eval);
    chk(iss_valid == ev, req, {63'd0, iss_valid}, {63'd0, ev});
    if (ev && iss_valid) begin
      chk(iss_op == eop, req, {56'd0, iss_op}, {56'd0, eop});
      chk(iss_val == eval, req, iss_val, eval);
    end
  endtask

  // begin a cycle: wait for falling edge and clear stimulus
  task automatic cyc();
    @(negedge clk);
    flush = 0; disp_valid = 0; disp_rdy = 0; disp_tag = 0; disp_val = 0;
    disp_op = 0; disp_dst = 0; res_vld = 0; res_tag = 0; res_val = 0;
  endtask

  task automatic disp(input logic [7:0] op, input logic [1:0] rdy,
                      input logic [3:0] t0, input logic [3:0] t1,
                      input logic [31:0] v0, input logic [31:0] v1);
    disp_valid = 1; disp_op = op; disp_dst = op[3:0]; disp_rdy = rdy;
    disp_tag = {t1, t0}; disp_val = {v1, v0};
  endtask

  task automatic bus(input int b, input logic [3:0] t, input logic [31:0] v);
    res_vld[b] = 1'b1;
    res_tag[b*4 +: 4] = t;
    res_val[b*32 +: 32] = v;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; eu_busy = 0;
    cyc(); cyc();
    rst_n = 1;
    #1;
    // R1 empty after reset
    chk(iss_valid == 0, "R1 iss", {63'd0, iss_valid}, 64'd0);
    chk(full == 0, "R1 full", {63'd0, full}, 64'd0);
    cyc(); #1;
    chk_iss("R1 idle", 0, 0, 0);

    // R5/R3 sweep over ready flags and unit state
    for (int busy = 0; busy < 2; busy++) begin
      for (int r = 0; r < 4; r++) begin
        logic [7:0] op;
        op = 8'h10 + 8'(busy*4 + r);
        cyc(); eu_busy = busy[0];
        disp(op, r[1:0], 4'd1, 4'd2, 32'hA000 + 32'(op), 32'hB000 + 32'(op));
        #1;
        chk_iss("R5 bypass sweep", (r == 3) && (busy == 0), op,
                {32'hB000 + 32'(op), 32'hA000 + 32'(op)});
        cyc(); eu_busy = 0; flush = 1; #1;
        chk_iss("R8 flush quiet", 0, 0, 0);
        cyc(); #1;
        chk_iss("R8 nothing left", 0, 0, 0);
      end
    end

    // R3 stored ready entry waits for unit
    cyc(); eu_busy = 1; disp(8'h21, 2'b11, 0, 0, 32'h1, 32'h2); #1;
    chk_iss("R3 busy no issue", 0, 0, 0);
    cyc(); #1;
    chk_iss("R3 still busy", 0, 0, 0);
    cyc(); eu_busy = 0; #1;
    chk_iss("R3 issue when free", 1, 8'h21, {32'h2, 32'h1});
    cyc(); #1;
    chk_iss("R3 gone", 0, 0, 0);

    // R4 wake from load bus, wrong tag ignored
    cyc(); disp(8'h31, 2'b01, 4'd0, 4'd5, 32'h3100, 32'h0); #1;
    chk_iss("R4 pending", 0, 0, 0);
    cyc(); bus(0, 4'd3, 32'hDEAD0003);
    cyc(); #1;
    chk_iss("R4 wrong tag", 0, 0, 0);
    bus(1, 4'd5, 32'hCAFE0005);
    cyc(); #1;
    chk_iss("R4 load wake", 1, 8'h31, {32'hCAFE0005, 32'h3100});

    // R4 wake in the dispatch clock
    cyc(); disp(8'h41, 2'b10, 4'd7, 4'd0, 32'h0, 32'h4141);
    bus(0, 4'd7, 32'h77); #1;
    chk_iss("R4 same-clock capture", 0, 0, 0);
    cyc(); #1;
    chk_iss("R4 dispatch wake", 1, 8'h41, {32'h4141, 32'h77});

    // R6/R7/R2 order, full, drop, refill
    cyc(); eu_busy = 1; disp(8'h51, 2'b00, 4'd2, 4'd2, 0, 0);
    cyc(); eu_busy = 1; disp(8'h52, 2'b00, 4'd3, 4'd3, 0, 0); #1;
    chk(full == 0, "R7 one free", {63'd0, full}, 64'd0);
    cyc(); eu_busy = 1; disp(8'h53, 2'b11, 0, 0, 32'h5, 32'h5);
    bus(0, 4'd3, 32'h33); #1;
    chk(full == 1, "R7 full", {63'd0, full}, 64'd1);
    cyc(); eu_busy = 1; bus(1, 4'd2, 32'h22); #1;
    chk(full == 1, "R7 still full", {63'd0, full}, 64'd1);
    cyc(); eu_busy = 0; disp(8'h54, 2'b00, 4'hE, 4'hE, 0, 0); #1;
    chk(full == 0, "R7 release on issue", {63'd0, full}, 64'd0);
    chk_iss("R6 oldest first", 1, 8'h51, {32'h22, 32'h22});
    cyc(); #1;
    chk_iss("R6 younger next", 1, 8'h52, {32'h33, 32'h33});
    cyc(); #1;
    chk_iss("R2 dropped while full", 0, 0, 0);
    bus(0, 4'hE, 32'hEE);
    cyc(); #1;
    chk_iss("R7 refill issues", 1, 8'h54, {32'hEE, 32'hEE});

    // R9 stored beats bypass
    cyc(); eu_busy = 1; disp(8'h61, 2'b11, 0, 0, 32'h61, 32'h16);
    cyc(); eu_busy = 0; disp(8'h62, 2'b11, 0, 0, 32'h62, 32'h26); #1;
    chk_iss("R9 stored first", 1, 8'h61, {32'h16, 32'h61});
    cyc(); #1;
    chk_iss("R9 dispatched later", 1, 8'h62, {32'h26, 32'h62});
    cyc(); #1;
    chk_iss("R9 empty", 0, 0, 0);

    // R8 flush drops stored and concurrent dispatch
    cyc(); disp(8'h71, 2'b00, 4'd9, 4'd9, 0, 0);
    cyc(); flush = 1; disp(8'h72, 2'b11, 0, 0, 32'h7, 32'h7); #1;
    chk_iss("R8 flush cycle", 0, 0, 0);
    cyc(); bus(0, 4'd9, 32'h99); #1;
    chk(full == 0, "R8 emptied", {63'd0, full}, 64'd0);
    cyc(); #1;
    chk_iss("R8 no stale wake", 0, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule